// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block produces the two timing strobes of an 8051-style multiplexed external memory bus: an active-high address-latch strobe and an active-low program-store read strobe. A machine-cycle phase counter runs from the oscillator clock. Its length is 12 clocks by default and 6 clocks in the fast mode. Each strobe is decoded from the phase.

Every machine cycle has two halves. Each half holds one latch pulse, one sixth of the cycle long. When code comes from external memory, a read pulse follows the latch pulse in that half. A cycle marked as an external data-memory access loses its second latch pulse and both read pulses. A control bit can suppress the latch strobe completely.

The mode and the three flags are taken only at a machine-cycle boundary, so a cycle never changes shape part way through. All outputs are registered, and the phase index is brought out so the cycle position can be observed.

Top module: `ext_bus_strobe_seq`

## Requirements
- R1: In slow mode (`fast_mode_i`=0) `phase_o` counts 0,1,...,11 on successive clocks, then wraps to 0.
- R2: In fast mode (`fast_mode_i`=1) `phase_o` counts 0..5, then wraps to 0.
- R3: With latch suppression off and no data access, `ale_o` is 1 exactly at phases 0,1,6,7 in slow mode and at phases 0,3 in fast mode. This gives two pulses per machine cycle, at one sixth and one third of the clock rate respectively.
- R4: In a data-access cycle (`xdata_cyc_i`=1) the second-half latch pulse is omitted (phases 6,7 slow; phase 3 fast), and the first-half pulse remains.
- R5: With `ale_off_i`=1, `ale_o` stays 0 for the whole machine cycle.
- R6: With `ext_code_i`=1 and no data access, `psen_n_o` is 0 exactly at phases 3,4,5,9,10,11 in slow mode and at phases 1,2,4,5 in fast mode, giving two read pulses per cycle.
- R7: In a data-access cycle both read pulses are skipped, and `psen_n_o` stays 1.
- R8: With `ext_code_i`=0, `psen_n_o` stays 1.
- R9: `psen_n_o` is never 0 while `ale_o` is 1.
- R10: The inputs `fast_mode_i`, `ext_code_i`, `xdata_cyc_i` and `ale_off_i` are sampled only on the clock edge that starts a machine cycle (phase becomes 0). A change part way through a cycle first takes effect in the next cycle.
- R11: While `rst_i` is 1 at a clock edge, `phase_o` becomes 0, `ale_o` 0 and `psen_n_o` 1, and the sampled settings return to slow mode, internal code, no data access and latch enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous reset, active high |
| fast_mode_i | input | 1 | 1 selects the 6-clock machine cycle |
| ext_code_i | input | 1 | 1 when code is fetched from external memory |
| xdata_cyc_i | input | 1 | 1 marks the machine cycle as an external data access |
| ale_off_i | input | 1 | 1 suppresses the address-latch strobe |
| ale_o | output | 1 | Address-latch strobe, active high |
| psen_n_o | output | 1 | Program-store read strobe, active low |
| phase_o | output | 4 | Current oscillator-clock position within the machine cycle |

## Verification
The bench's main target is the pulse pattern inside each half-cycle in both modes. It checks that the latch pulse lasts exactly one sixth of the cycle, and that the read strobe starts only after the latch strobe has fallen. An off-by-one decode would overlap the two strobes or shift a pulse. A wrong drop rule in data-access cycles would leave an extra latch pulse or a stray read pulse.

Settings are changed part way through a cycle to check that they are sampled only at the boundary. A design that sampled them at once would cut a cycle short or lose a latch pulse early.

Reset is applied part way through a cycle to check that it restarts at phase 0 with idle strobes and slow-mode settings.

// File: rtl/strobe_seq_pkg.sv
package strobe_seq_pkg;
  typedef struct packed {
    logic fast;
    logic ext_code;
    logic xdata;
    logic ale_off;
  } bus_cfg_t;

  localparam bus_cfg_t CFG_RESET = '{fast: 1'b0, ext_code: 1'b0, xdata: 1'b0, ale_off: 1'b0};
endpackage

// File: rtl/strobe_phase_ctr.sv
module strobe_phase_ctr
  import strobe_seq_pkg::*;
#(
  parameter int CYC_SLOW = 12,
  parameter int CYC_FAST = 6,
  parameter int PW       = 4
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  bus_cfg_t      cfg_i,
  output logic [PW-1:0] phase_q,
  output bus_cfg_t      cfg_q,
  output logic [PW-1:0] phase_nxt,
  output bus_cfg_t      cfg_nxt
);
  localparam logic [PW-1:0] LAST_SLOW = PW'(CYC_SLOW - 1);
  localparam logic [PW-1:0] LAST_FAST = PW'(CYC_FAST - 1);

  logic          wrap;
  logic [PW-1:0] last;

  always_comb begin
    last      = cfg_q.fast ? LAST_FAST : LAST_SLOW;
    wrap      = (phase_q == last);
    phase_nxt = wrap ? '0 : phase_q + PW'(1);
    cfg_nxt   = wrap ? cfg_i : cfg_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= '0;
      cfg_q   <= CFG_RESET;
    end else begin
      phase_q <= phase_nxt;
      cfg_q   <= cfg_nxt;
    end
  end
endmodule

// File: rtl/strobe_decode.sv
module strobe_decode #(
  parameter int CYC = 12,
  parameter int PW  = 4
) (
  input  logic [PW-1:0] phase_i,
  input  logic          ext_i,
  input  logic          xdata_i,
  input  logic          ale_off_i,
  output logic          ale_o,
  output logic          psen_n_o
);
  localparam int WID = CYC / 6;
  localparam int HLF = CYC / 2;
  localparam logic [PW-1:0] HLF_C   = PW'(HLF);
  localparam logic [PW-1:0] WID_C   = PW'(WID);
  localparam logic [PW-1:0] RD_ON_C = PW'(WID + WID / 2);

  logic          second;
  logic [PW-1:0] pos;

  always_comb begin
    second   = (phase_i >= HLF_C);
    pos      = second ? phase_i - HLF_C : phase_i;
    ale_o    = !ale_off_i && (pos < WID_C) && !(xdata_i && second);
    psen_n_o = !(ext_i && !xdata_i && (pos >= RD_ON_C));
  end
endmodule

// File: rtl/ext_bus_strobe_seq.sv
module ext_bus_strobe_seq
  import strobe_seq_pkg::*;
#(
  parameter int CYC_SLOW = 12,
  parameter int CYC_FAST = 6,
  localparam int PW      = $clog2(CYC_SLOW)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          fast_mode_i,
  input  logic          ext_code_i,
  input  logic          xdata_cyc_i,
  input  logic          ale_off_i,
  output logic          ale_o,
  output logic          psen_n_o,
  output logic [PW-1:0] phase_o
);
  bus_cfg_t      cfg_in, cfg_cur, cfg_nxt;
  logic [PW-1:0] phase_nxt;
  logic [1:0]    ale_v, psen_v;

  assign cfg_in = '{fast: fast_mode_i, ext_code: ext_code_i,
                    xdata: xdata_cyc_i, ale_off: ale_off_i};

  strobe_phase_ctr #(.CYC_SLOW(CYC_SLOW), .CYC_FAST(CYC_FAST), .PW(PW)) u_ctr (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .cfg_i    (cfg_in),
    .phase_q  (phase_o),
    .cfg_q    (cfg_cur),
    .phase_nxt(phase_nxt),
    .cfg_nxt  (cfg_nxt)
  );

  for (genvar g = 0; g < 2; g++) begin : g_mode
    localparam int CYC = (g == 1) ? CYC_FAST : CYC_SLOW;
    strobe_decode #(.CYC(CYC), .PW(PW)) u_dec (
      .phase_i  (phase_nxt),
      .ext_i    (cfg_nxt.ext_code),
      .xdata_i  (cfg_nxt.xdata),
      .ale_off_i(cfg_nxt.ale_off),
      .ale_o    (ale_v[g]),
      .psen_n_o (psen_v[g])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ale_o    <= 1'b0;
      psen_n_o <= 1'b1;
    end else begin
      ale_o    <= ale_v[cfg_nxt.fast];
      psen_n_o <= psen_v[cfg_nxt.fast];
    end
  end
endmodule

// File: rtl/ext_bus_strobe_seq_chk.sv
module ext_bus_strobe_seq_chk
  import strobe_seq_pkg::*;
#(
  parameter int CYC_SLOW = 12,
  parameter int CYC_FAST = 6,
  parameter int PW       = 4
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          ale_o,
  input logic          psen_n_o,
  input logic [PW-1:0] phase_o,
  input bus_cfg_t      cfg_i
);
  // R1: phase advances by one or restarts at zero
  p_phase_step_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (phase_o == '0) || (phase_o == $past(phase_o) + PW'(1)));

  // R2: fast cycle never exceeds its length
  p_fast_bound_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    cfg_i.fast |-> (phase_o < PW'(CYC_FAST)));

  // R5: latch strobe held idle when suppressed
  p_ale_off_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    cfg_i.ale_off |-> !ale_o);

  // R7: no read pulse in a data-access cycle
  p_xdata_psen_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    cfg_i.xdata |-> psen_n_o);

  // R8: no read pulse for internal code
  p_int_code_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !cfg_i.ext_code |-> psen_n_o);

  // R9: strobes never overlap
  p_no_overlap_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !(ale_o && !psen_n_o));

  // R10: settings only change when a cycle starts
  p_cfg_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    (phase_o != '0) |-> $stable(cfg_i));

  // R11: reset idles everything
  p_reset_idle_r11: assert property (@(posedge clk_i)
    rst_i |=> (phase_o == '0) && !ale_o && psen_n_o && (cfg_i == CFG_RESET));
endmodule

bind ext_bus_strobe_seq ext_bus_strobe_seq_chk #(
  .CYC_SLOW(CYC_SLOW), .CYC_FAST(CYC_FAST), .PW(PW)
) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .ale_o   (ale_o),
  .psen_n_o(psen_n_o),
  .phase_o (phase_o),
  .cfg_i   (cfg_cur)
);

// File: tb/ext_bus_strobe_seq_tb_top.sv
module ext_bus_strobe_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       fast, ext, xd, off;
  logic       ale, psen_n;
  logic [3:0] phase;
  int         total = 0;
  int         bad   = 0;
  bit         done  = 0;

  always #2 clk = ~clk;

  ext_bus_strobe_seq dut_i (
    .clk_i(clk), .rst_i(rst), .fast_mode_i(fast), .ext_code_i(ext),
    .xdata_cyc_i(xd), .ale_off_i(off), .ale_o(ale), .psen_n_o(psen_n), .phase_o(phase)
  );

  // {fast, ext, xdata, ale_off, ale pulses[1:0], read pulses[1:0]}
  localparam logic [7:0] VEC [9] = '{
    {4'b0100, 2'd2, 2'd2}, {4'b0110, 2'd1, 2'd0}, {4'b0000, 2'd2, 2'd0},
    {4'b0101, 2'd0, 2'd2}, {4'b0111, 2'd0, 2'd0}, {4'b1100, 2'd2, 2'd2},
    {4'b1110, 2'd1, 2'd0}, {4'b1001, 2'd0, 2'd0}, {4'b1010, 2'd1, 2'd0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_ale(int p, int cyc, bit x, bit o);
    int w = cyc / 6; int h = cyc / 2; int q = p % h;
    return !o && (q < w) && !(x && p >= h);
  endfunction

  function automatic bit exp_psen_n(int p, int cyc, bit e, bit x);
    int w = cyc / 6; int h = cyc / 2; int q = p % h;
    return !(e && !x && q >= w + w / 2);
  endfunction

  task automatic align();
    do @(negedge clk); while (phase != 4'd0);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; fast = 0; ext = 0; xd = 0; off = 0;
    repeat (3) @(negedge clk);
    chk(phase == 0, "R11 reset phase", phase, 0);
    chk(ale == 0, "R11 reset ale", ale, 0);
    chk(psen_n == 1, "R11 reset psen", psen_n, 1);
    rst = 1'b0;

    foreach (VEC[i]) begin
      int cyc, na, np;
      bit pa, pp;
      {fast, ext, xd, off} = VEC[i][7:4];
      cyc = fast ? 6 : 12;
      repeat (26) @(negedge clk);
      align();
      na = 0; np = 0; pa = 0; pp = 1;
      for (int k = 0; k < cyc; k++) begin
        bit ea, ep;
        ea = exp_ale(k, cyc, xd, off);
        ep = exp_psen_n(k, cyc, ext, xd);
        chk(phase == 4'(k), fast ? "R2 phase" : "R1 phase", phase, k);
        chk(ale == ea, off ? "R5 ale" : (xd ? "R4 ale" : "R3 ale"), ale, ea);
        chk(psen_n == ep, !ext ? "R8 psen" : (xd ? "R7 psen" : "R6 psen"), psen_n, ep);
        chk(!(ale && !psen_n), "R9 overlap", psen_n, 1);
        if (ale && !pa) na++;
        if (!psen_n && pp) np++;
        pa = ale; pp = psen_n;
        @(negedge clk);
      end
      chk(phase == 0, fast ? "R2 wrap" : "R1 wrap", phase, 0);
      chk(na == int'(VEC[i][3:2]), "R3 ale pulse count", na, VEC[i][3:2]);
      chk(np == int'(VEC[i][1:0]), "R6 psen pulse count", np, VEC[i][1:0]);
    end

    // R10: mode change mid-cycle waits for the boundary
    {fast, ext, xd, off} = 4'b0100;
    repeat (26) @(negedge clk);
    align();
    repeat (3) @(negedge clk);
    fast = 1;
    repeat (8) @(negedge clk);
    chk(phase == 11, "R10 slow cycle completes", phase, 11);
    @(negedge clk);
    chk(phase == 0, "R10 boundary", phase, 0);
    repeat (5) @(negedge clk);
    chk(phase == 5, "R2 fast last", phase, 5);
    @(negedge clk);
    chk(phase == 0, "R2 fast wrap", phase, 0);

    // R10: latch suppression set mid-cycle is deferred
    fast = 0;
    repeat (14) @(negedge clk);
    align();
    repeat (2) @(negedge clk);
    off = 1;
    repeat (4) @(negedge clk);
    chk(phase == 6 && ale == 1, "R10 ale kept this cycle", ale, 1);
    repeat (6) @(negedge clk);
    chk(phase == 0 && ale == 0, "R5 ale off next cycle", ale, 0);

    // R11: reset mid-cycle
    off = 0; fast = 1;
    repeat (15) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk(phase == 0, "R11 mid reset phase", phase, 0);
    chk(ale == 0 && psen_n == 1, "R11 mid reset strobes", {ale, psen_n}, 1);
    rst = 0;
    repeat (7) @(negedge clk);
    chk(phase == 7, "R11 slow mode after reset", phase, 7);
    chk(ale == 1, "R11 ale after reset", ale, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule